// File: doc/BRIEF.md
# Operand and Operation Command Capture

This block takes the first operand and the chosen operation of a small calculator datapath. Two command lines, one asking for addition and one for subtraction, come from outside the clock domain. No register in the block is clocked by them. Each line passes through a synchroniser on the free-running system clock. A rising edge is found by comparing the synchronised level with its value one clock earlier.

When a command edge is seen, the block stores the value on the operand bus. It also records whether the pending operation is a subtraction and raises a flag saying that an operand is held. A single register stage with one next-state function drives all three outputs, so every output has exactly one driver. If both commands rise in the same cycle, subtraction wins. A synchronous clear empties the stored state and takes priority over any capture on the same edge.

Top module: `op_cmd_latch`

## Requirements
- R1: While reset is held, and right after it is released, `operand_q` is zero, `sub_mode` is 0 and `loaded` is 0.
- R2: A rising edge on `add_req` (with no rising edge on `sub_req` and no `clear`) sets `sub_mode` to 0 and `loaded` to 1, and stores `operand_in`.
- R3: A rising edge on `sub_req` (with no `clear`) sets `sub_mode` to 1 and `loaded` to 1, and stores `operand_in`.
- R4: A command first sampled high at clock edge k updates the outputs at edge k+2, using the `operand_in` value present at edge k+2. The outputs keep their old values after edges k and k+1.
- R5: A command held high causes one capture only. Between command edges and clears, the outputs hold, whatever `operand_in` does.
- R6: If `add_req` and `sub_req` rise in the same sampled cycle, the subtract capture is taken (`sub_mode` = 1).
- R7: `clear` sampled high at a clock edge sets `operand_q` to zero, `sub_mode` to 0 and `loaded` to 0. This also happens when a command capture falls on the same edge, and that capture is lost.
- R8: A falling edge on either command changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clear | input | 1 | Synchronous clear of the stored state, active high |
| add_req | input | 1 | Asynchronous add command level |
| sub_req | input | 1 | Asynchronous subtract command level |
| operand_in | input | WIDTH | Operand bus sampled on a capture |
| operand_q | output | WIDTH | Stored operand |
| sub_mode | output | 1 | 1 when the stored operation is subtraction |
| loaded | output | 1 | 1 when an operand is held |

## Verification
The bench checks capture latency to the exact edge. A design with one synchroniser stage too few or too many would update a cycle early or late, and would store a different `operand_in` value. It holds a command high while `operand_in` changes, and then lets the command fall. A level-sensitive design would then keep reloading the operand, and an any-edge design would capture on the falling edge. It also drives both commands at once and puts `clear` on the very edge of a capture. A design with the wrong priority would show `sub_mode` = 0 in the first case, or would keep `loaded` set in the second.

// File: rtl/cmdl_pkg.sv
package cmdl_pkg;

  // Resolved action for one clock edge, in priority order
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_ADD   = 2'd1,
    ACT_SUB   = 2'd2,
    ACT_CLEAR = 2'd3
  } cmd_act_e;

  localparam int unsigned NUM_CMDS = 2;
  localparam int unsigned CMD_ADD_IDX = 0;
  localparam int unsigned CMD_SUB_IDX = 1;

endpackage

// File: rtl/cmdl_sync.sv
module cmdl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cmdl_rise.sv
module cmdl_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= level;
    end
  end

  assign pulse = level & ~prev_q;

endmodule

// File: rtl/cmdl_arbiter.sv
module cmdl_arbiter
  import cmdl_pkg::*;
(
  input  logic     clear,
  input  logic     add_rise,
  input  logic     sub_rise,
  output cmd_act_e action
);

  always_comb begin
    if (clear) begin
      action = ACT_CLEAR;
    end else if (sub_rise) begin
      action = ACT_SUB;
    end else if (add_rise) begin
      action = ACT_ADD;
    end else begin
      action = ACT_IDLE;
    end
  end

endmodule

// File: rtl/cmdl_store.sv
module cmdl_store
  import cmdl_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_act_e         action,
  input  logic [WIDTH-1:0] operand_in,
  output logic [WIDTH-1:0] operand_q,
  output logic             sub_mode,
  output logic             loaded
);

  logic [WIDTH-1:0] operand_d;
  logic             sub_d;
  logic             loaded_d;
  logic             upd_en;

  assign upd_en = (action != ACT_IDLE);

  always_comb begin
    operand_d = operand_q;
    sub_d     = sub_mode;
    loaded_d  = loaded;
    case (action)
      ACT_CLEAR: begin
        operand_d = '0;
        sub_d     = 1'b0;
        loaded_d  = 1'b0;
      end
      ACT_SUB: begin
        operand_d = operand_in;
        sub_d     = 1'b1;
        loaded_d  = 1'b1;
      end
      ACT_ADD: begin
        operand_d = operand_in;
        sub_d     = 1'b0;
        loaded_d  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      operand_q <= '0;
      sub_mode  <= 1'b0;
      loaded    <= 1'b0;
    end else if (upd_en) begin
      operand_q <= operand_d;
      sub_mode  <= sub_d;
      loaded    <= loaded_d;
    end
  end

endmodule

// File: rtl/op_cmd_latch.sv
module op_cmd_latch
  import cmdl_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add_req,
  input  logic             sub_req,
  input  logic [WIDTH-1:0] operand_in,
  output logic [WIDTH-1:0] operand_q,
  output logic             sub_mode,
  output logic             loaded
);

  logic [NUM_CMDS-1:0] cmd_raw;
  logic [NUM_CMDS-1:0] cmd_sync;
  logic [NUM_CMDS-1:0] cmd_rise;
  logic                add_rise;
  logic                sub_rise;
  cmd_act_e            action;

  assign cmd_raw[CMD_ADD_IDX] = add_req;
  assign cmd_raw[CMD_SUB_IDX] = sub_req;

  for (genvar g = 0; g < NUM_CMDS; g++) begin : g_cmd
    cmdl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmd_raw[g]),
      .q     (cmd_sync[g])
    );
    cmdl_rise u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .level (cmd_sync[g]),
      .pulse (cmd_rise[g])
    );
  end

  assign add_rise = cmd_rise[CMD_ADD_IDX];
  assign sub_rise = cmd_rise[CMD_SUB_IDX];

  cmdl_arbiter u_arb (
    .clear    (clear),
    .add_rise (add_rise),
    .sub_rise (sub_rise),
    .action   (action)
  );

  cmdl_store #(.WIDTH(WIDTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .action     (action),
    .operand_in (operand_in),
    .operand_q  (operand_q),
    .sub_mode   (sub_mode),
    .loaded     (loaded)
  );

endmodule

// File: rtl/op_cmd_latch_chk.sv
module op_cmd_latch_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             add_rise,
  input logic             sub_rise,
  input logic [WIDTH-1:0] operand_in,
  input logic [WIDTH-1:0] operand_q,
  input logic             sub_mode,
  input logic             loaded
);

  // R1
  empty_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> (operand_q == '0 && !sub_mode));

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!loaded && operand_q == '0 && !sub_mode));

  // R3
  sub_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_rise && !clear) |=> (sub_mode && loaded && operand_q == $past(operand_in)));

  // R2
  add_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add_rise && !sub_rise && !clear) |=> (!sub_mode && loaded && operand_q == $past(operand_in)));

  // R5
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !add_rise && !sub_rise) |=> ($stable(operand_q) && $stable(sub_mode) && $stable(loaded)));

  // R5
  single_add_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_rise |=> !add_rise);

  // R5
  single_sub_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_rise |=> !sub_rise);

endmodule

bind op_cmd_latch op_cmd_latch_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .add_rise   (add_rise),
  .sub_rise   (sub_rise),
  .operand_in (operand_in),
  .operand_q  (operand_q),
  .sub_mode   (sub_mode),
  .loaded     (loaded)
);

// File: tb/sim_op_cmd_latch.sv
`timescale 1ns/1ps
module sim_op_cmd_latch;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear = 1'b0;
  logic         add_req = 1'b0;
  logic         sub_req = 1'b0;
  logic [W-1:0] operand_in = '0;
  logic [W-1:0] operand_q;
  logic         sub_mode;
  logic         loaded;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  bit    model_on = 1'b0;
  string cur_req = "R1";

  // reference state
  bit         hist_add[$];
  bit         hist_sub[$];
  bit [W-1:0] exp_op;
  bit         exp_sub;
  bit         exp_ld;

  always #5 clk = ~clk;

  op_cmd_latch #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .add_req(add_req), .sub_req(sub_req),
    .operand_in(operand_in), .operand_q(operand_q), .sub_mode(sub_mode), .loaded(loaded)
  );

  // Behavioural model: a command seen high at edge n-2 and low at edge n-3 acts at edge n.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_add = '{0, 0, 0};
      hist_sub = '{0, 0, 0};
      exp_op = '0; exp_sub = 1'b0; exp_ld = 1'b0;
    end else begin
      bit ra, rs;
      hist_add.push_front(add_req);
      hist_sub.push_front(sub_req);
      ra = hist_add[2] && !hist_add[3];
      rs = hist_sub[2] && !hist_sub[3];
      void'(hist_add.pop_back());
      void'(hist_sub.pop_back());
      if (clear) begin
        exp_op = '0; exp_sub = 1'b0; exp_ld = 1'b0;
      end else if (rs) begin
        exp_op = operand_in; exp_sub = 1'b1; exp_ld = 1'b1;
      end else if (ra) begin
        exp_op = operand_in; exp_sub = 1'b0; exp_ld = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      checks++;
      if (operand_q !== exp_op || sub_mode !== exp_sub || loaded !== exp_ld) begin
        errors++;
        $display("FAIL %s model: got op=%h sub=%b ld=%b expected op=%h sub=%b ld=%b",
                 cur_req, operand_q, sub_mode, loaded, exp_op, exp_sub, exp_ld);
      end
    end
  end

  task automatic expect_out(input string req, input logic [W-1:0] op, input logic sm, input logic ld);
    checks++;
    if (operand_q !== op || sub_mode !== sm || loaded !== ld) begin
      errors++;
      $display("FAIL %s: got op=%h sub=%b ld=%b expected op=%h sub=%b ld=%b",
               req, operand_q, sub_mode, loaded, op, sm, ld);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_n(1);
    cur_req = "R1";
    expect_out("R1", '0, 1'b0, 1'b0);
    wait_n(2);
    rst_n = 1'b1;
    model_on = 1'b1;
    wait_n(1);
    expect_out("R1", '0, 1'b0, 1'b0);

    // R2 / R4: add capture and its latency
    cur_req = "R4";
    operand_in = 8'h3C; add_req = 1'b1;
    wait_n(2);
    expect_out("R4", '0, 1'b0, 1'b0);
    wait_n(1);
    expect_out("R2", 8'h3C, 1'b0, 1'b1);

    // R5: held command, changing operand
    cur_req = "R5";
    operand_in = 8'h55;
    wait_n(5);
    expect_out("R5", 8'h3C, 1'b0, 1'b1);

    // R8: falling edge does nothing
    cur_req = "R8";
    add_req = 1'b0;
    wait_n(5);
    expect_out("R8", 8'h3C, 1'b0, 1'b1);

    // R3: subtract capture
    cur_req = "R3";
    operand_in = 8'hA5; sub_req = 1'b1;
    wait_n(3);
    expect_out("R3", 8'hA5, 1'b1, 1'b1);
    sub_req = 1'b0;
    wait_n(4);
    expect_out("R8", 8'hA5, 1'b1, 1'b1);

    // R6: simultaneous edges
    cur_req = "R6";
    operand_in = 8'h12; add_req = 1'b1; sub_req = 1'b1;
    wait_n(3);
    expect_out("R6", 8'h12, 1'b1, 1'b1);
    add_req = 1'b0; sub_req = 1'b0;
    wait_n(4);

    cur_req = "R2";
    operand_in = 8'h34; add_req = 1'b1;
    wait_n(3);
    expect_out("R2", 8'h34, 1'b0, 1'b1);
    add_req = 1'b0;
    wait_n(4);

    // R7: plain clear
    cur_req = "R7";
    clear = 1'b1;
    wait_n(1);
    clear = 1'b0;
    expect_out("R7", '0, 1'b0, 1'b0);

    // R7: clear on the capture edge wins
    operand_in = 8'h77; add_req = 1'b1;
    wait_n(2);
    clear = 1'b1;
    wait_n(1);
    clear = 1'b0;
    expect_out("R7", '0, 1'b0, 1'b0);
    wait_n(3);
    expect_out("R7", '0, 1'b0, 1'b0);
    add_req = 1'b0;
    wait_n(4);

    // mixed traffic against the model
    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) add_req = ~add_req;
      if ($urandom_range(0, 7) == 0) sub_req = ~sub_req;
      clear = ($urandom_range(0, 31) == 0);
      operand_in = W'($urandom);
      wait_n(1);
    end
    clear = 1'b0;
    wait_n(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule